// File: doc/BRIEF.md
# Delay-Line Phase Search-and-Track Controller

This controller drives a 9-bit tap index into an external delay line. Its aim is to bring a measured phase to a programmed target. A signed phase sample arrives with a valid strobe. The controller first searches the tap range for a tap whose phase is acceptable. It can then keep tracking that phase by nudging the tap one gain step per sample.

The search starts at a programmable tap. It runs downward, upward or alternately on both sides, according to a direction field. It first visits only the interior of the line, clear of a guard band at each end. Only when the interior yields nothing does it try the guard-band taps, in the same order. The acceptance window is either exact or ±2 around the target. After a search that finds nothing, the controller either carries on from the tap it ends on or starts the whole search again from the start tap. A separate track-only mode skips the search entirely.

Configuration is expected to stay stable while the block is enabled. Dropping the enable returns the controller to its start position.

Top module: `dline_phase_ctrl`

## Requirements
- R1: `tap_o` never exceeds 432. A tracking step that would pass 432 stops at 432.
- R2: During reset, `tap_o` is 0 and all flags are low. While `en_i` is low, `tap_o` takes `start_tap_i` one clock later and `locked_o`, `tracking_o` and `fail_o` are low. A start value above 432 is used as 432.
- R3: `mode_i` selects the operation. 00 searches and then tracks. 01 tracks only, starting from the start tap. 10 searches only. 11 behaves exactly like a low `en_i`. `tracking_o` is high only while the tap is being tracked.
- R4: The search order is set by `dir_i`. With 00 it visits start, start−1, start−2 and so on. With 01 it visits start, start+1 and so on. With 10 (and 11) it visits start, start+1, start−1, start+2, start−2 and so on, up to an offset of 432. Each in-range candidate is placed on `tap_o` and held until one valid sample has been judged; if that sample does not match, the search moves to the next candidate.
- R5: With guard width G = `guard_i`, the first search pass uses only taps in [G, 432−G]. A second pass, in the same order, uses only the taps outside that range.
- R6: `phase_i` and `target_i` are 5-bit two's complement, and error = phase − target. With `exact_i`=1 a sample is accepted only when the error is 0; with `exact_i`=0 it is accepted when |error| ≤ 2. An accepted sample during the search raises `locked_o`, clears `fail_o`, and moves to tracking (mode 00) or to a hold (mode 10).
- R7: When both passes end without a match, `fail_o` goes high. With `fail_rst_i`=0, mode 00 begins tracking from the current tap with `locked_o` low, and mode 10 holds the current tap. With `fail_rst_i`=1, `tap_o` returns to the start tap on the same edge and the search restarts from its first pass. `fail_o` stays high until a search match or a disable.
- R8: While tracking, each valid sample moves the tap by `gain_i`, and saturates at 0 and 432. The direction is up when the error is positive and `slope_i`=0, or when the error is negative and `slope_i`=1; in the other two cases it is down. A zero error, or a cycle without a valid sample, leaves the tap unchanged.
- R9: While tracking, an in-window sample sets `locked_o`. The fourth consecutive out-of-window sample clears it.
- R10: After a search-only match, `tap_o` is frozen, `locked_o` stays high and `tracking_o` stays low until the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable |
| gain_i | input | 2 | Tracking step size |
| target_i | input | 5 | Target phase, two's complement |
| slope_i | input | 1 | Lock polarity: 0 = phase falls as the tap rises |
| start_tap_i | input | 9 | Start tap of the search |
| mode_i | input | 2 | Operating mode |
| dir_i | input | 2 | Search direction |
| guard_i | input | 5 | Guard band width at each end |
| exact_i | input | 1 | 1 = exact match, 0 = ±2 window |
| fail_rst_i | input | 1 | 1 = restart the search after a failure |
| phase_i | input | 5 | Measured phase, two's complement |
| phase_vld_i | input | 1 | Phase sample strobe |
| tap_o | output | 9 | Delay-line tap index |
| locked_o | output | 1 | Phase within the acceptance window |
| tracking_o | output | 1 | Tracking loop active |
| fail_o | output | 1 | Last search found no match |

## Verification
The bench models phase as a falling, rising or constant function of the tap. Falling and rising ramps placed so that the only match lies above or below the start tap confirm that each direction setting visits candidates in its own order and lands on the first matching tap. A ramp whose only match lies inside the lower guard band shows that the interior pass finishes before guard taps are tried. A constant phase that never matches exercises both failure policies. A constant phase far from the target drives tracking into both saturation limits, and toggling the constant in and out of the window counts the four-sample unlock.

// File: rtl/dlpc_pkg.sv
package dlpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_TRACK  = 2'd2,
    ST_HOLD   = 2'd3
  } dlpc_state_e;

  localparam logic [1:0] MODE_SRCH_TRK = 2'b00;
  localparam logic [1:0] MODE_TRK_ONLY = 2'b01;
  localparam logic [1:0] MODE_SRCH_ONLY = 2'b10;
  localparam logic [1:0] MODE_OFF = 2'b11;

  localparam logic [1:0] DIR_DOWN = 2'b00;
  localparam logic [1:0] DIR_UP = 2'b01;
endpackage

// File: rtl/dlpc_cand_gen.sv
module dlpc_cand_gen
  import dlpc_pkg::*;
#(
  parameter int TAP_W   = 9,
  parameter int TAP_MAX = 432,
  parameter int GB_W    = 5
) (
  input  logic [TAP_W-1:0] start_i,
  input  logic [GB_W-1:0]  guard_i,
  input  logic [1:0]       dir_i,
  input  logic [TAP_W:0]   ofs_i,
  input  logic             neg_i,
  input  logic             gpass_i,
  output logic [TAP_W-1:0] cand_o,
  output logic             cand_ok_o,
  output logic [TAP_W:0]   ofs_nxt_o,
  output logic             neg_nxt_o,
  output logic             seq_done_o
);
  localparam int CW = TAP_W + 3;
  localparam logic signed [CW-1:0] MAX_S = CW'(TAP_MAX);
  localparam logic signed [CW-1:0] ZERO_S = '0;

  logic signed [CW-1:0] start_s, ofs_s, cand_s, lo_s, hi_s;
  logic in_line, interior;

  assign start_s = $signed(CW'(start_i));
  assign ofs_s   = $signed(CW'(ofs_i));
  assign lo_s    = $signed(CW'(guard_i));
  assign hi_s    = MAX_S - lo_s;
  assign cand_s  = neg_i ? (start_s - ofs_s) : (start_s + ofs_s);

  assign in_line  = (cand_s >= ZERO_S) && (cand_s <= MAX_S);
  assign interior = (cand_s >= lo_s) && (cand_s <= hi_s);

  assign cand_o     = cand_s[TAP_W-1:0];
  assign cand_ok_o  = in_line && (gpass_i ? !interior : interior);
  assign seq_done_o = ofs_i > (TAP_W+1)'(TAP_MAX);

  // single-sided sweeps grow the offset every step; two-sided pairs +d with -d
  always_comb begin
    ofs_nxt_o = ofs_i + 1'b1;
    neg_nxt_o = neg_i;
    if (dir_i != DIR_DOWN && dir_i != DIR_UP) begin
      if (!neg_i && ofs_i != '0) begin
        ofs_nxt_o = ofs_i;
        neg_nxt_o = 1'b1;
      end else begin
        neg_nxt_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dlpc_phase_eval.sv
module dlpc_phase_eval #(
  parameter int PH_W = 5,
  parameter int TOL  = 2
) (
  input  logic [PH_W-1:0] phase_i,
  input  logic [PH_W-1:0] target_i,
  input  logic            exact_i,
  output logic            in_win_o,
  output logic            err_pos_o,
  output logic            err_zero_o
);
  localparam logic signed [PH_W:0] TOL_S = (PH_W+1)'(TOL);

  logic signed [PH_W:0] err;

  assign err = $signed({phase_i[PH_W-1], phase_i}) - $signed({target_i[PH_W-1], target_i});

  assign err_zero_o = (err == '0);
  assign err_pos_o  = !err[PH_W] && !err_zero_o;
  assign in_win_o   = exact_i ? err_zero_o : ((err >= -TOL_S) && (err <= TOL_S));
endmodule

// File: rtl/dlpc_step.sv
module dlpc_step #(
  parameter int TAP_W   = 9,
  parameter int TAP_MAX = 432,
  parameter int GAIN_W  = 2
) (
  input  logic [TAP_W-1:0]  tap_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              err_pos_i,
  input  logic              err_zero_i,
  input  logic              slope_i,
  output logic [TAP_W-1:0]  tap_o
);
  logic [TAP_W:0]   sum;
  logic [TAP_W-1:0] gain_w;
  logic             up;

  assign gain_w = TAP_W'(gain_i);
  assign sum    = {1'b0, tap_i} + {1'b0, gain_w};
  assign up     = err_pos_i ^ slope_i;

  always_comb begin
    if (err_zero_i)
      tap_o = tap_i;
    else if (up)
      tap_o = (sum > (TAP_W+1)'(TAP_MAX)) ? TAP_W'(TAP_MAX) : sum[TAP_W-1:0];
    else
      tap_o = (tap_i < gain_w) ? '0 : (tap_i - gain_w);
  end
endmodule

// File: rtl/dline_phase_ctrl.sv
module dline_phase_ctrl
  import dlpc_pkg::*;
#(
  parameter int TAP_W    = 9,
  parameter int TAP_MAX  = 432,
  parameter int PH_W     = 5,
  parameter int GB_W     = 5,
  parameter int GAIN_W   = 2,
  parameter int TOL      = 2,
  parameter int MISS_LIM = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [PH_W-1:0]   target_i,
  input  logic              slope_i,
  input  logic [TAP_W-1:0]  start_tap_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        dir_i,
  input  logic [GB_W-1:0]   guard_i,
  input  logic              exact_i,
  input  logic              fail_rst_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic              phase_vld_i,
  output logic [TAP_W-1:0]  tap_o,
  output logic              locked_o,
  output logic              tracking_o,
  output logic              fail_o
);
  localparam int MW = (MISS_LIM > 2) ? $clog2(MISS_LIM) : 1;
  localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIM - 1);

  dlpc_state_e      state_q;
  logic [TAP_W-1:0] tap_q, start_c, cand, step_tap;
  logic [TAP_W:0]   ofs_q, ofs_nxt;
  logic             neg_q, neg_nxt, gpass_q, armed_q;
  logic             locked_q, fail_q;
  logic [MW-1:0]    miss_q;
  logic             cand_ok, seq_done, in_win, err_pos, err_zero, neg_init, go_off;

  assign start_c  = (start_tap_i > TAP_W'(TAP_MAX)) ? TAP_W'(TAP_MAX) : start_tap_i;
  assign neg_init = (dir_i == DIR_DOWN);
  assign go_off   = !en_i || (mode_i == MODE_OFF);

  dlpc_cand_gen #(.TAP_W(TAP_W), .TAP_MAX(TAP_MAX), .GB_W(GB_W)) u_cand (
    .start_i   (start_c),
    .guard_i   (guard_i),
    .dir_i     (dir_i),
    .ofs_i     (ofs_q),
    .neg_i     (neg_q),
    .gpass_i   (gpass_q),
    .cand_o    (cand),
    .cand_ok_o (cand_ok),
    .ofs_nxt_o (ofs_nxt),
    .neg_nxt_o (neg_nxt),
    .seq_done_o(seq_done)
  );

  dlpc_phase_eval #(.PH_W(PH_W), .TOL(TOL)) u_eval (
    .phase_i   (phase_i),
    .target_i  (target_i),
    .exact_i   (exact_i),
    .in_win_o  (in_win),
    .err_pos_o (err_pos),
    .err_zero_o(err_zero)
  );

  dlpc_step #(.TAP_W(TAP_W), .TAP_MAX(TAP_MAX), .GAIN_W(GAIN_W)) u_step (
    .tap_i     (tap_q),
    .gain_i    (gain_i),
    .err_pos_i (err_pos),
    .err_zero_i(err_zero),
    .slope_i   (slope_i),
    .tap_o     (step_tap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tap_q    <= '0;
      ofs_q    <= '0;
      neg_q    <= 1'b0;
      gpass_q  <= 1'b0;
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
      fail_q   <= 1'b0;
      miss_q   <= '0;
    end else if (go_off) begin
      state_q  <= ST_IDLE;
      tap_q    <= start_c;
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          tap_q   <= start_c;
          ofs_q   <= '0;
          neg_q   <= neg_init;
          gpass_q <= 1'b0;
          armed_q <= 1'b0;
          miss_q  <= '0;
          state_q <= (mode_i == MODE_TRK_ONLY) ? ST_TRACK : ST_SEARCH;
        end
        ST_SEARCH: begin
          if (armed_q) begin
            // candidate on the line: judge one sample
            if (phase_vld_i) begin
              armed_q <= 1'b0;
              if (in_win) begin
                locked_q <= 1'b1;
                fail_q   <= 1'b0;
                miss_q   <= '0;
                state_q  <= (mode_i == MODE_SRCH_ONLY) ? ST_HOLD : ST_TRACK;
              end
            end
          end else if (seq_done) begin
            ofs_q <= '0;
            neg_q <= neg_init;
            if (!gpass_q) begin
              gpass_q <= 1'b1;
            end else begin
              fail_q <= 1'b1;
              if (fail_rst_i) begin
                tap_q   <= start_c;
                gpass_q <= 1'b0;
              end else begin
                miss_q  <= '0;
                state_q <= (mode_i == MODE_SRCH_ONLY) ? ST_HOLD : ST_TRACK;
              end
            end
          end else begin
            ofs_q <= ofs_nxt;
            neg_q <= neg_nxt;
            if (cand_ok) begin
              tap_q   <= cand;
              armed_q <= 1'b1;
            end
          end
        end
        ST_TRACK: begin
          if (phase_vld_i) begin
            tap_q <= step_tap;
            if (in_win) begin
              locked_q <= 1'b1;
              miss_q   <= '0;
            end else if (miss_q == MISS_LAST) begin
              locked_q <= 1'b0;
            end else begin
              miss_q <= miss_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign tap_o      = tap_q;
  assign locked_o   = locked_q;
  assign tracking_o = (state_q == ST_TRACK);
  assign fail_o     = fail_q;
endmodule

// File: rtl/dline_phase_ctrl_chk.sv
module dline_phase_ctrl_chk #(
  parameter int TAP_W   = 9,
  parameter int TAP_MAX = 432,
  parameter int PH_W    = 5,
  parameter int GAIN_W  = 2,
  parameter int TOL     = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [GAIN_W-1:0] gain_i,
  input logic [PH_W-1:0]   target_i,
  input logic [TAP_W-1:0]  start_tap_i,
  input logic [1:0]        mode_i,
  input logic              exact_i,
  input logic [PH_W-1:0]   phase_i,
  input logic              phase_vld_i,
  input logic [TAP_W-1:0]  tap_o,
  input logic              locked_o,
  input logic              tracking_o,
  input logic              fail_o
);
  logic [TAP_W-1:0]  start_lim, prev_tap;
  logic [GAIN_W-1:0] prev_gain;
  logic              win_now;
  int                ph_i, tg_i, dif, mov;

  assign start_lim = (start_tap_i > TAP_W'(TAP_MAX)) ? TAP_W'(TAP_MAX) : start_tap_i;
  assign ph_i      = int'($signed(phase_i));
  assign tg_i      = int'($signed(target_i));
  assign dif       = ph_i - tg_i;
  assign win_now   = exact_i ? (dif == 0) : ((dif >= -TOL) && (dif <= TOL));
  assign mov       = int'(tap_o) - int'(prev_tap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_tap  <= '0;
      prev_gain <= '0;
    end else begin
      prev_tap  <= tap_o;
      prev_gain <= gain_i;
    end
  end

  AST_TAP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_o <= TAP_W'(TAP_MAX)); // R1

  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (tap_o == $past(start_lim)) && !locked_o && !tracking_o && !fail_o); // R2

  AST_MODE_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |=> !locked_o && !tracking_o && !fail_o); // R3

  AST_LOCK_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(phase_vld_i) && $past(win_now)); // R6

  AST_TRACK_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tracking_o && $past(tracking_o)) |-> (mov <= int'(prev_gain)) && (mov >= -int'(prev_gain))); // R8

  AST_TRACK_NO_SAMPLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tracking_o && $past(tracking_o) && !$past(phase_vld_i)) |-> $stable(tap_o)); // R8

  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !tracking_o && $past(locked_o && !tracking_o)) |-> $stable(tap_o)); // R10
endmodule

bind dline_phase_ctrl dline_phase_ctrl_chk #(
  .TAP_W(TAP_W), .TAP_MAX(TAP_MAX), .PH_W(PH_W), .GAIN_W(GAIN_W), .TOL(TOL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .gain_i(gain_i), .target_i(target_i),
  .start_tap_i(start_tap_i), .mode_i(mode_i), .exact_i(exact_i), .phase_i(phase_i),
  .phase_vld_i(phase_vld_i), .tap_o(tap_o), .locked_o(locked_o),
  .tracking_o(tracking_o), .fail_o(fail_o)
);

// File: tb/dline_phase_ctrl_tb.sv
module dline_phase_ctrl_tb;
  localparam int TMAX = 432;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] gain = 2'd1;
  logic [4:0] target = 5'h1A;
  logic       slope = 1'b0;
  logic [8:0] start = 9'd220;
  logic [1:0] mode = 2'b00;
  logic [1:0] dir = 2'b10;
  logic [4:0] guard = 5'd11;
  logic       exact = 1'b1;
  logic       frst = 1'b0;
  logic       vld = 1'b0;
  logic [4:0] phase;
  logic [8:0] tap;
  logic       locked, tracking, fail;

  int    fn_sel = 0;
  int    fn_c = 240;
  int    vdiv = 1;
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R4";

  always #4 clk = ~clk;

  function automatic logic [4:0] ph_fn(input logic [8:0] t, input int sel, input int c);
    int v;
    if (sel == 0) v = (c - int'(t)) / 4;
    else if (sel == 1) v = (int'(t) - c) / 4;
    else v = c;
    if (v > 15) v = 15;
    if (v < -16) v = -16;
    return v[4:0];
  endfunction

  assign phase = ph_fn(tap, fn_sel, fn_c);

  dline_phase_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .gain_i(gain), .target_i(target),
    .slope_i(slope), .start_tap_i(start), .mode_i(mode), .dir_i(dir), .guard_i(guard),
    .exact_i(exact), .fail_rst_i(frst), .phase_i(phase), .phase_vld_i(vld),
    .tap_o(tap), .locked_o(locked), .tracking_o(tracking), .fail_o(fail)
  );

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_state, m_tap, m_miss;
  bit m_lock, m_fail, m_arm, m_pass;
  int m_q[$];

  function automatic int startc();
    return (int'(start) > TMAX) ? TMAX : int'(start);
  endfunction

  function automatic bit m_valid(input int c, input bit pass);
    bit inl, intr;
    inl  = (c >= 0) && (c <= TMAX);
    intr = (c >= int'(guard)) && (c <= TMAX - int'(guard));
    return inl && (pass ? !intr : intr);
  endfunction

  function automatic bit m_win(input int e);
    return exact ? (e == 0) : (e >= -2 && e <= 2);
  endfunction

  task automatic m_fill();
    int s;
    s = startc();
    m_q.delete();
    if (dir == 2'b01) for (int d = 0; d <= TMAX; d++) m_q.push_back(s + d);
    else if (dir == 2'b00) for (int d = 0; d <= TMAX; d++) m_q.push_back(s - d);
    else begin
      m_q.push_back(s);
      for (int d = 1; d <= TMAX; d++) begin
        m_q.push_back(s + d);
        m_q.push_back(s - d);
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    int e, c;
    if (!rst_n) begin
      m_state = 0; m_tap = 0; m_lock = 0; m_fail = 0; m_arm = 0; m_pass = 0; m_miss = 0;
    end else if (!en || mode == 2'b11) begin
      m_state = 0; m_tap = startc(); m_lock = 0; m_fail = 0; m_arm = 0;
    end else begin
      e = int'($signed(phase)) - int'($signed(target));
      case (m_state)
        0: begin
          m_tap = startc(); m_miss = 0; m_arm = 0; m_pass = 0;
          if (mode == 2'b01) m_state = 2;
          else begin m_state = 1; m_fill(); end
        end
        1: begin
          if (m_arm) begin
            if (vld) begin
              m_arm = 0;
              if (m_win(e)) begin
                m_lock = 1; m_fail = 0; m_miss = 0;
                m_state = (mode == 2'b10) ? 3 : 2;
              end
            end
          end else if (m_q.size() == 0) begin
            if (!m_pass) begin m_pass = 1; m_fill(); end
            else begin
              m_fail = 1;
              if (frst) begin m_tap = startc(); m_pass = 0; m_fill(); end
              else begin m_miss = 0; m_state = (mode == 2'b10) ? 3 : 2; end
            end
          end else begin
            c = m_q.pop_front();
            if (m_valid(c, m_pass)) begin m_tap = c; m_arm = 1; end
          end
        end
        2: begin
          if (vld) begin
            if (e != 0) begin
              if ((e > 0) != slope) m_tap = m_tap + int'(gain);
              else m_tap = m_tap - int'(gain);
              if (m_tap > TMAX) m_tap = TMAX;
              if (m_tap < 0) m_tap = 0;
            end
            if (m_win(e)) begin m_lock = 1; m_miss = 0; end
            else if (m_miss == 3) m_lock = 0;
            else m_miss++;
          end
        end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(tap) == m_tap, cur_req, "model tap", int'(tap), m_tap);
      chk(locked == m_lock, cur_req, "model locked", int'(locked), int'(m_lock));
      chk(tracking == (m_state == 2), cur_req, "model tracking", int'(tracking), int'(m_state == 2));
      chk(fail == m_fail, cur_req, "model fail", int'(fail), int'(m_fail));
    end
  end

  always @(negedge clk) vld <= (vdiv <= 1) || ((cyc % vdiv) == 0);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic restart();
    en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
  endtask

  task automatic wait_lock(input int maxc);
    for (int i = 0; i < maxc && !locked; i++) @(negedge clk);
  endtask

  task automatic wait_fail(input int maxc);
    for (int i = 0; i < maxc && !fail; i++) @(negedge clk);
  endtask

  initial begin
    // reset
    repeat (3) @(negedge clk);
    cur_req = "R2";
    chk(tap == 9'd0 && !locked && !tracking && !fail, "R2", "reset tap/flags", int'(tap), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(tap) == 220, "R2", "disabled tap at start", int'(tap), 220);

    // search+track, two-sided, exact; match at 264
    cur_req = "R4"; fn_sel = 0; fn_c = 240; mode = 2'b00; dir = 2'b10;
    restart();
    wait_lock(3000);
    chk(int'(tap) == 264, "R4", "two-sided first match tap", int'(tap), 264);
    chk(int'($signed(phase)) == -6, "R6", "exact lock phase", int'($signed(phase)), -6);
    @(negedge clk);
    chk(tracking == 1'b1 && fail == 1'b0, "R3", "tracking after search lock", int'(tracking), 1);
    repeat (20) @(negedge clk);
    chk(int'(tap) == 264, "R8", "zero error keeps tap", int'(tap), 264);
    en = 1'b0;
    @(negedge clk);
    chk(int'(tap) == 220 && !locked && !tracking && !fail, "R2", "disable returns to start", int'(tap), 220);

    // search only, downward, rising ramp; match at 76
    cur_req = "R10"; fn_sel = 1; fn_c = 100; mode = 2'b10; dir = 2'b00; vdiv = 3;
    restart();
    wait_lock(3000);
    chk(int'(tap) == 76, "R4", "downward first match tap", int'(tap), 76);
    repeat (30) @(negedge clk);
    chk(int'(tap) == 76 && locked && !tracking, "R10", "search-only hold", int'(tap), 76);

    // upward, +-2 window; match at 256
    cur_req = "R6"; fn_sel = 0; fn_c = 240; dir = 2'b01; exact = 1'b0; vdiv = 1;
    restart();
    wait_lock(3000);
    chk(int'(tap) == 256, "R6", "window accepts phase -4", int'(tap), 256);
    exact = 1'b1;

    // guard fallback: only taps 5..8 match
    cur_req = "R5"; fn_c = -19; dir = 2'b10;
    restart();
    wait_lock(6000);
    chk(int'(tap) == 8 && locked && !fail, "R5", "guard-band match tap", int'(tap), 8);

    // no match, search only, continue policy
    cur_req = "R7"; fn_sel = 2; fn_c = 0; frst = 1'b0;
    restart();
    wait_fail(6000);
    @(negedge clk);
    chk(fail && !locked && !tracking && int'(tap) == 0, "R7", "fail holds last guard tap", int'(tap), 0);

    // no match, search+track, restart policy
    mode = 2'b00; frst = 1'b1;
    restart();
    wait_fail(6000);
    chk(fail && int'(tap) == 220 && !tracking, "R7", "restart returns to start", int'(tap), 220);
    repeat (50) @(negedge clk);
    frst = 1'b0;

    // track only, slope 1, gain 2, rising ramp; settles at 76
    cur_req = "R8"; mode = 2'b01; gain = 2'd2; slope = 1'b1; fn_sel = 1; fn_c = 100; vdiv = 3;
    restart();
    wait_lock(3000);
    chk(int'(tap) == 76 && tracking, "R8", "track-only converges", int'(tap), 76);

    // saturation high and low
    cur_req = "R1"; gain = 2'd3; slope = 1'b0; fn_sel = 2; fn_c = 15; vdiv = 1;
    restart();
    repeat (100) @(negedge clk);
    chk(int'(tap) == 432, "R1", "upper saturation", int'(tap), 432);
    cur_req = "R8"; fn_c = -16;
    restart();
    repeat (100) @(negedge clk);
    chk(int'(tap) == 0, "R8", "lower saturation", int'(tap), 0);

    // unlock after four misses
    cur_req = "R9"; gain = 2'd0; fn_c = -6;
    restart();
    repeat (4) @(negedge clk);
    chk(locked == 1'b1, "R9", "lock in track", int'(locked), 1);
    fn_c = 5;
    repeat (3) @(negedge clk);
    chk(locked == 1'b1, "R9", "still locked after 3 misses", int'(locked), 1);
    @(negedge clk);
    chk(locked == 1'b0, "R9", "unlock on 4th miss", int'(locked), 0);
    fn_c = -6;
    @(negedge clk);
    chk(locked == 1'b1, "R9", "relock on match", int'(locked), 1);

    // mode 11 idle and start clamp
    cur_req = "R3"; mode = 2'b11; start = 9'd300;
    restart();
    repeat (10) @(negedge clk);
    chk(int'(tap) == 300 && !locked && !tracking && !fail, "R3", "mode 11 idle", int'(tap), 300);
    cur_req = "R2"; start = 9'd500;
    @(negedge clk);
    chk(int'(tap) == 432, "R2", "start clamp", int'(tap), 432);

    en = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule